// File: doc/BRIEF.md
# Pulse-Driven Power Mode Sequencer

This block controls the power state of a receiver core from one host control line. After power is applied it waits in a low-power power-up state until a real-time-clock-running input goes high. It then moves to a ready-to-start state. From there, every control pulse whose high time falls inside a window counted in clock cycles steps the core to its next mode. Which mode comes next depends on the mode the core is in now. Four other modes exist: full-on, sleep, a duty-cycled low-power state, and a single-fix standby that runs one fix cycle per pulse.

The control line goes through a synchroniser. Its high time is counted in system clock cycles. A pulse takes effect when it falls, and only if its width lies strictly between a lower and an upper limit. After a pulse is accepted, a hold-off window begins, and any pulse that starts inside it is dropped as bounce. The first start from ready-to-start is flagged as a cold start. The block also drives enables for the main clock and for the host serial pins, and a status output that is high only in full-on.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_o is 0 (power-up) and stays 0 until rtc_ok_i is sampled high. The next clock edge then gives mode 1 (ready-to-start). Control pulses in power-up change no mode.
- R2: ctrl_i goes through a two-flop synchroniser. A qualifying pulse changes the mode at the third rising clock edge after ctrl_i is first sampled low at its fall.
- R3: The width W of a pulse is the number of rising edges at which the synchronised line is high. A pulse is accepted only if MIN_CYC < W < MAX_CYC. Any other pulse has no effect on the mode or on any output.
- R4: An accepted pulse in ready-to-start gives full-on. In the cycle where full-on is entered this way, cold_start_o is high for exactly one cycle. It is never high at any other time.
- R5: An accepted pulse in full-on picks the next mode from lp_sel_i: 0 or 3 gives sleep, 1 gives duty-cycled, 2 gives single-fix standby.
- R6: An accepted pulse in sleep or in duty-cycled gives full-on.
- R7: A pulse is dropped if its synchronised rise is sampled within GAP_CYC clock edges after the edge that acted on the previous accepted pulse.
- R8: running_o is high only in full-on. mclk_en_o and hostio_oe_o are high in full-on and in fix-running, and low in every other mode.
- R9: An accepted pulse in single-fix standby gives fix-running. While fix-running, fix_done_i gives sleep at the next edge, and control pulses have no effect.
- R10: Asserting rst_ni low at any time, asynchronously, gives mode 0 with all outputs low.
- R11: mode_o encoding: 0 power-up, 1 ready-to-start, 2 full-on, 3 sleep, 4 duty-cycled, 5 single-fix standby, 6 fix-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 1 | Host control pulse line, asynchronous |
| rtc_ok_i | input | 1 | Real-time clock running |
| fix_done_i | input | 1 | Fix cycle finished |
| lp_sel_i | input | 2 | Low-power target chosen when leaving full-on |
| running_o | output | 1 | Core running status, high in full-on |
| mclk_en_o | output | 1 | Main clock enable |
| hostio_oe_o | output | 1 | Host transmit/receive pin drive enable; low means high impedance |
| cold_start_o | output | 1 | One-cycle flag on the first start |
| mode_o | output | 3 | Current mode code |

## Verification
Some properties are checked on every cycle:
- power-up holds until the clock-ready input is seen;
- every mode change has a cause, namely an accepted pulse, clock-ready or fix-done;
- an accepted pulse never falls inside the hold-off window;
- cold start only marks a ready-to-start to full-on step;
- fix-done always exits to sleep;
- sleep always has the clock and pin enables off.

The exact width limits at one cycle either side of each bound need the bench's scenarios. So do the three-edge latency, the mode-dependent routing by lp_sel_i, the dropping of bounce pulses, and reset in mid-run. The bench model follows these cycle by cycle.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    M_PWRUP = 3'd0,
    M_READY = 3'd1,
    M_FULL  = 3'd2,
    M_SLEEP = 3'd3,
    M_DUTY  = 3'd4,
    M_PTF   = 3'd5,
    M_FIX   = 3'd6
  } pm_mode_e;

  localparam logic [1:0] LP_SLEEP = 2'd0;
  localparam logic [1:0] LP_DUTY  = 2'd1;
  localparam logic [1:0] LP_FIX   = 2'd2;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pms_pulse_qual.sv
module pms_pulse_qual #(
  parameter int MIN_CYC = 9000,
  parameter int MAX_CYC = 100000000,
  parameter int GAP_CYC = 100000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic evt_o
);
  localparam int WW = $clog2(MAX_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [WW-1:0] MIN_W = WW'(MIN_CYC);
  localparam logic [WW-1:0] MAX_W = WW'(MAX_CYC);
  localparam logic [GW-1:0] GAP_W = GW'(GAP_CYC);

  logic          lvl_q;
  logic          armed_q;
  logic [WW-1:0] wcnt_q;
  logic [GW-1:0] gap_q;
  logic          rise, fall;

  assign rise  = lvl_i & ~lvl_q;
  assign fall  = ~lvl_i & lvl_q;
  assign evt_o = fall & armed_q & (wcnt_q > MIN_W) & (wcnt_q < MAX_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
      wcnt_q  <= '0;
      gap_q   <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (lvl_i) begin
        if (rise)                 wcnt_q <= WW'(1);
        else if (wcnt_q != MAX_W) wcnt_q <= wcnt_q + WW'(1);
      end
      // a pulse is armed only if its rise lands outside the hold-off window
      if (rise) armed_q <= (gap_q == '0);
      if (evt_o)             gap_q <= GAP_W;
      else if (gap_q != '0)  gap_q <= gap_q - GW'(1);
    end
  end

  AST_EVT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (gap_q == '0)); // R7

  AST_WIDTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= MAX_W); // R3
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  logic       rtc_ok_i,
  input  logic       fix_done_i,
  input  logic [1:0] lp_sel_i,
  output pm_mode_e   mode_o,
  output logic       cold_start_o
);
  pm_mode_e mode_q, mode_d;
  logic     cold_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_PWRUP: if (rtc_ok_i) mode_d = M_READY;
      M_READY: if (evt_i)    mode_d = M_FULL;
      M_FULL: if (evt_i) begin
        case (lp_sel_i)
          LP_DUTY: mode_d = M_DUTY;
          LP_FIX:  mode_d = M_PTF;
          default: mode_d = M_SLEEP;
        endcase
      end
      M_SLEEP: if (evt_i)      mode_d = M_FULL;
      M_DUTY:  if (evt_i)      mode_d = M_FULL;
      M_PTF:   if (evt_i)      mode_d = M_FIX;
      M_FIX:   if (fix_done_i) mode_d = M_SLEEP;
      default: mode_d = M_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_PWRUP;
      cold_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cold_q <= (mode_q == M_READY) & evt_i;
    end
  end

  assign mode_o       = mode_q;
  assign cold_start_o = cold_q;

  AST_PWRUP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_PWRUP && !rtc_ok_i) |=> (mode_q == M_PWRUP)); // R1

  AST_COLD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_start_o |-> (mode_q == M_FULL && $past(mode_q) == M_READY)); // R4

  AST_MODE_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(evt_i || rtc_ok_i || fix_done_i)); // R3

  AST_FIX_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_FIX && fix_done_i) |=> (mode_q == M_SLEEP)); // R9
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int MIN_CYC     = 9000,
  parameter int MAX_CYC     = 100000000,
  parameter int GAP_CYC     = 100000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_i,
  input  logic       rtc_ok_i,
  input  logic       fix_done_i,
  input  logic [1:0] lp_sel_i,
  output logic       running_o,
  output logic       mclk_en_o,
  output logic       hostio_oe_o,
  output logic       cold_start_o,
  output logic [2:0] mode_o
);
  logic     ctrl_s;
  logic     evt;
  pm_mode_e mode;
  logic     core_on;

  pms_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_i),
    .q_o   (ctrl_s)
  );

  pms_pulse_qual #(
    .MIN_CYC(MIN_CYC),
    .MAX_CYC(MAX_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ctrl_s),
    .evt_o (evt)
  );

  pms_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .rtc_ok_i    (rtc_ok_i),
    .fix_done_i  (fix_done_i),
    .lp_sel_i    (lp_sel_i),
    .mode_o      (mode),
    .cold_start_o(cold_start_o)
  );

  assign core_on     = (mode == M_FULL) || (mode == M_FIX);
  assign running_o   = (mode == M_FULL);
  assign mclk_en_o   = core_on;
  assign hostio_oe_o = core_on;
  assign mode_o      = mode;

  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> (!mclk_en_o && !hostio_oe_o && !running_o)); // R8
endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int MIN = 8;
  localparam int MAX = 50;
  localparam int GAP = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl = 1'b0;
  logic rtc = 1'b0;
  logic fdone = 1'b0;
  logic [1:0] sel = 2'd0;
  logic running, mclk_en, hio_oe, cold;
  logic [2:0] mode;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pwr_mode_seq #(.MIN_CYC(MIN), .MAX_CYC(MAX), .GAP_CYC(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .rtc_ok_i(rtc),
    .fix_done_i(fdone), .lp_sel_i(sel), .running_o(running),
    .mclk_en_o(mclk_en), .hostio_oe_o(hio_oe), .cold_start_o(cold),
    .mode_o(mode)
  );

  // behavioural reference
  int m_mode, m_cold, m_s1, m_s2, m_hp, m_w, m_arm, m_gap;
  always @(posedge clk or negedge rst_n) begin
    int nxt, cl;
    bit up, dn, ev;
    if (!rst_n) begin
      m_mode = 0; m_cold = 0; m_s1 = 0; m_s2 = 0; m_hp = 0;
      m_w = 0; m_arm = 0; m_gap = 0;
    end else begin
      up = (m_s2 == 1) && (m_hp == 0);
      dn = (m_s2 == 0) && (m_hp == 1);
      ev = dn && (m_arm == 1) && (m_w > MIN) && (m_w < MAX);
      nxt = m_mode; cl = 0;
      case (m_mode)
        0: if (rtc) nxt = 1;
        1: if (ev) begin nxt = 2; cl = 1; end
        2: if (ev) nxt = (sel == 2'd1) ? 4 : (sel == 2'd2) ? 5 : 3;
        3: if (ev) nxt = 2;
        4: if (ev) nxt = 2;
        5: if (ev) nxt = 6;
        6: if (fdone) nxt = 3;
        default: nxt = 0;
      endcase
      if (m_s2 == 1) m_w = up ? 1 : ((m_w < MAX) ? m_w + 1 : MAX);
      if (up) m_arm = (m_gap == 0) ? 1 : 0;
      if (ev) m_gap = GAP; else if (m_gap > 0) m_gap = m_gap - 1;
      m_hp = m_s2; m_s2 = m_s1; m_s1 = int'(ctrl);
      m_mode = nxt; m_cold = cl;
    end
  end

  always @(negedge clk) begin
    int e_run, e_on;
    if (!done) begin
      e_run = (m_mode == 2) ? 1 : 0;
      e_on  = (m_mode == 2 || m_mode == 6) ? 1 : 0;
      n_cmp++;
      if (int'(mode) != m_mode || int'(running) != e_run || int'(mclk_en) != e_on ||
          int'(hio_oe) != e_on || int'(cold) != m_cold) begin
        n_bad++;
        $display("FAIL %s cyc %0d: mode/run/clk/io/cold act %0d/%0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d/%0d",
                 cur_req, cyc, mode, running, mclk_en, hio_oe, cold,
                 m_mode, e_run, e_on, e_on, m_cold);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk); ctrl = 1'b1;
    repeat (n) @(negedge clk);
    ctrl = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic hold_off();
    repeat (GAP + 20) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act %0d exp done", cyc);
      finish_run();
    end
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(negedge clk);
    chk("R10", int'(mode), 0);
    chk("R10", int'(running | mclk_en | hio_oe | cold), 0);
    rst_n = 1'b1;

    cur_req = "R1";
    pulse(20); settle();
    chk("R1", int'(mode), 0);
    hold_off();
    rtc = 1'b1;
    @(negedge clk);
    chk("R1", int'(mode), 1);
    chk("R11", int'(mode), 1);

    cur_req = "R3";
    pulse(MIN); settle();
    chk("R3", int'(mode), 1);
    repeat (10) @(negedge clk);

    cur_req = "R4";
    pulse(MIN + 1);
    @(negedge clk); @(negedge clk);
    chk("R2", int'(mode), 1);
    @(negedge clk);
    chk("R2", int'(mode), 2);
    chk("R4", int'(cold), 1);
    @(negedge clk);
    chk("R4", int'(cold), 0);

    cur_req = "R7";
    repeat (3) @(negedge clk);
    pulse(20); settle();
    chk("R7", int'(mode), 2);
    hold_off();

    cur_req = "R5";
    sel = 2'd0;
    pulse(MAX - 1); settle();
    chk("R5", int'(mode), 3);
    chk("R8", int'(mclk_en | hio_oe | running), 0);
    hold_off();

    cur_req = "R3";
    pulse(MAX); settle();
    chk("R3", int'(mode), 3);
    repeat (20) @(negedge clk);

    cur_req = "R6";
    pulse(20); settle();
    chk("R6", int'(mode), 2);
    chk("R4", int'(cold), 0);
    chk("R8", int'(running), 1);
    hold_off();

    cur_req = "R5";
    sel = 2'd1;
    pulse(20); settle();
    chk("R5", int'(mode), 4);
    chk("R8", int'(mclk_en), 0);
    hold_off();
    cur_req = "R6";
    pulse(20); settle();
    chk("R6", int'(mode), 2);
    hold_off();

    cur_req = "R5";
    sel = 2'd2;
    pulse(20); settle();
    chk("R5", int'(mode), 5);
    hold_off();
    cur_req = "R9";
    pulse(20); settle();
    chk("R9", int'(mode), 6);
    chk("R8", int'(running), 0);
    chk("R8", int'(mclk_en & hio_oe), 1);
    hold_off();
    pulse(20); settle();
    chk("R9", int'(mode), 6);
    @(negedge clk); fdone = 1'b1;
    @(negedge clk); fdone = 1'b0;
    chk("R9", int'(mode), 3);
    hold_off();

    cur_req = "R5";
    sel = 2'd3;
    pulse(20); settle();
    chk("R6", int'(mode), 2);
    hold_off();
    pulse(20); settle();
    chk("R5", int'(mode), 3);
    hold_off();
    pulse(20); settle();
    chk("R6", int'(mode), 2);

    cur_req = "R10";
    #3 rst_n = 1'b0;
    @(negedge clk);
    chk("R10", int'(mode), 0);
    chk("R10", int'(running | mclk_en | hio_oe | cold), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", int'(mode), 1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule